// File: doc/BRIEF.md
# Bit-Serial Accumulator Processor

This block is a very small 32-bit processor that pushes every arithmetic result through a single one-bit full adder, one bit per clock. It has one accumulator and no register file. Any other working values live in ordinary memory words. The instruction set has four operations, and every instruction names exactly one memory word directly.

A single word-wide memory port carries three kinds of traffic: instruction fetches, operand reads and stores. Requests use a valid/ready handshake. While `mem_req_valid` is high and `mem_req_ready` is low, the processor holds the address, the write flag and the write data unchanged. A request is taken in the cycle where both are high. For a read, the word must appear on `mem_rdata` in the next cycle, and it must stay there until the next request is taken.

Each instruction runs through the same steps:
- A fetch.
- ADD and NOR then do an operand read and 32 serial shift cycles.
- STORE then issues one write request.
- The jump decision is made in the cycle the instruction word returns.

`instr_retired` pulses once per instruction, in the first cycle where all of that instruction's effects can be seen on `acc_o`, on `pc_o` and in memory.

Top module: `bitser_cpu`

## Requirements
- R1: While reset is held, `pc_o` and `acc_o` read zero and neither `mem_req_valid` nor `instr_retired` is asserted. One cycle after reset is released, a read request is presented for word address 0.
- R2: Instruction bits 31:30 select the operation: 00 ADD, 01 NOR, 10 STORE, 11 JMPNEG. Bits 29:0 are the direct word address of the operand or jump target.
- R3: ADD leaves the accumulator equal to the old accumulator plus the memory word, modulo 2^32. The carry ripples from bit 0 to bit 31 and the final carry out is dropped.
- R4: The carry flip-flop is cleared before bit 0 of every serial operation, so a carry left over from an earlier ADD never changes a later result.
- R5: NOR leaves the accumulator equal to the bitwise NOT of (accumulator OR memory word).
- R6: STORE writes the accumulator to the addressed word and leaves the accumulator unchanged. It retires in the cycle after its write request is taken.
- R7: JMPNEG loads the program counter with its address field when accumulator bit 31 is 1. Otherwise it acts as a plain step to the next word.
- R8: Every instruction that does not jump advances the program counter by exactly one word.
- R9: A request that is not yet taken keeps its address, write flag and write data stable. Memory stalls change the timing of retirement but never the results.
- R10: `instr_retired` is a one-cycle pulse. With no stalls, back-to-back instructions retire 36 cycles apart for ADD or NOR, 3 cycles apart for STORE and 2 cycles apart for JMPNEG.
- R11: The accumulator never changes in the cycle that follows a memory request. It is updated only by the serial shift cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 = store, 0 = read |
| mem_req_addr | output | 30 | Word address of the request |
| mem_req_wdata | output | 32 | Store data (the accumulator) |
| mem_rdata | input | 32 | Read word, valid the cycle after a read is taken |
| acc_o | output | 32 | Accumulator |
| pc_o | output | 30 | Program counter (word address) |
| instr_retired | output | 1 | One-cycle pulse per completed instruction |

## Verification
The adder is exercised with several operand pairs, each aimed at a different fault:
- 0x7FFFFFFF + 1 carries through every bit position.
- 0x80000000 + 0x80000000 wraps to zero.
- 0xFFFFFFFF + 1, followed by an add of zero, shows whether a stale carry survives into the next instruction.

NOR is driven with mixed, all-ones and complementary patterns, which separates it from OR, AND and ADD.

JMPNEG is run once with a negative accumulator and once with a positive one. Each result is then confirmed by which instruction executes next.

The same programs are repeated with pseudo-random ready stalls. This separates handshake or latency faults from datapath faults.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

  typedef enum logic [1:0] {
    OP_ADD    = 2'b00,
    OP_NOR    = 2'b01,
    OP_STORE  = 2'b10,
    OP_JMPNEG = 2'b11
  } opcode_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_FETCH,
    ST_IWAIT,
    ST_OREQ,
    ST_OWAIT,
    ST_EXEC,
    ST_STORE
  } phase_e;

endpackage

// File: rtl/bitser_bitalu.sv
module bitser_bitalu (
  input  logic a_bit,
  input  logic b_bit,
  input  logic cin,
  input  logic is_nor,
  output logic res_bit,
  output logic cout
);
  logic sum_bit;
  logic carry_gen;

  always_comb begin
    sum_bit   = a_bit ^ b_bit ^ cin;
    carry_gen = (a_bit & b_bit) | (cin & (a_bit ^ b_bit));
    res_bit   = is_nor ? ~(a_bit | b_bit) : sum_bit;
    cout      = is_nor ? 1'b0 : carry_gen;
  end
endmodule

// File: rtl/bitser_datapath.sv
module bitser_datapath
  import bitser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rdata,
  input  opcode_e           op,
  input  logic              ld_opd,
  input  logic              clr_carry,
  input  logic              shift_en,
  output logic [WORD_W-1:0] acc_q
);
  logic [WORD_W-1:0] opd_q;
  logic              carry_q;
  logic              res_bit;
  logic              cout;

  bitser_bitalu alu_i (
    .a_bit  (acc_q[0]),
    .b_bit  (opd_q[0]),
    .cin    (carry_q),
    .is_nor (op == OP_NOR),
    .res_bit(res_bit),
    .cout   (cout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      opd_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (ld_opd) begin
        opd_q <= rdata;
      end else if (shift_en) begin
        opd_q <= {1'b0, opd_q[WORD_W-1:1]};
      end
      if (clr_carry) begin
        carry_q <= 1'b0;
      end else if (shift_en) begin
        carry_q <= cout;
      end
      if (shift_en) begin
        acc_q <= {res_bit, acc_q[WORD_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/bitser_addr.sv
module bitser_addr
  import bitser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPC_W  = 2,
  parameter int ADDR_W = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr,
  input  logic              ld_instr,
  input  logic              pc_inc,
  input  logic              pc_jump,
  input  logic              addr_from_pc,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] req_addr,
  output opcode_e           op_q
);
  logic [ADDR_W-1:0] mar_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      op_q  <= OP_ADD;
    end else begin
      if (ld_instr) begin
        op_q  <= opcode_e'(instr[WORD_W-1 -: OPC_W]);
        mar_q <= instr[ADDR_W-1:0];
      end
      if (pc_jump) begin
        pc_q <= instr[ADDR_W-1:0];
      end else if (pc_inc) begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign req_addr = addr_from_pc ? pc_q : mar_q;
endmodule

// File: rtl/bitser_seq.sv
module bitser_seq
  import bitser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(WORD_W) + 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_ready,
  input  opcode_e fetched_op,
  input  logic    acc_sign,
  output logic    req_valid,
  output logic    req_write,
  output logic    addr_from_pc,
  output logic    ld_instr,
  output logic    pc_inc,
  output logic    pc_jump,
  output logic    ld_opd,
  output logic    clr_carry,
  output logic    shift_en,
  output logic    retire
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             done_now;

  always_comb begin
    st_d         = st_q;
    req_valid    = 1'b0;
    req_write    = 1'b0;
    addr_from_pc = 1'b0;
    ld_instr     = 1'b0;
    pc_inc       = 1'b0;
    pc_jump      = 1'b0;
    ld_opd       = 1'b0;
    clr_carry    = 1'b0;
    shift_en     = 1'b0;
    done_now     = 1'b0;
    unique case (st_q)
      ST_BOOT: st_d = ST_FETCH;
      ST_FETCH: begin
        req_valid    = 1'b1;
        addr_from_pc = 1'b1;
        if (req_ready) st_d = ST_IWAIT;
      end
      ST_IWAIT: begin
        ld_instr = 1'b1;
        unique case (fetched_op)
          OP_ADD, OP_NOR: begin
            pc_inc = 1'b1;
            st_d   = ST_OREQ;
          end
          OP_STORE: begin
            pc_inc = 1'b1;
            st_d   = ST_STORE;
          end
          OP_JMPNEG: begin
            pc_jump  = acc_sign;
            pc_inc   = ~acc_sign;
            done_now = 1'b1;
            st_d     = ST_FETCH;
          end
        endcase
      end
      ST_OREQ: begin
        req_valid = 1'b1;
        if (req_ready) st_d = ST_OWAIT;
      end
      ST_OWAIT: begin
        ld_opd    = 1'b1;
        clr_carry = 1'b1;
        st_d      = ST_EXEC;
      end
      ST_EXEC: begin
        shift_en = 1'b1;
        if (cnt_q == LAST_BIT) begin
          done_now = 1'b1;
          st_d     = ST_FETCH;
        end
      end
      ST_STORE: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        if (req_ready) begin
          done_now = 1'b1;
          st_d     = ST_FETCH;
        end
      end
      default: st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_BOOT;
      cnt_q  <= '0;
      retire <= 1'b0;
    end else begin
      st_q   <= st_d;
      retire <= done_now;
      if (ld_opd) begin
        cnt_q <= '0;
      end else if (shift_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitser_cpu.sv
module bitser_cpu
  import bitser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPC_W  = 2,
  parameter int ADDR_W = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              instr_retired
);
  localparam int CNT_W = $clog2(WORD_W) + 1;

  logic    addr_from_pc, ld_instr, pc_inc, pc_jump;
  logic    ld_opd, clr_carry, shift_en;
  opcode_e op_q;
  opcode_e fetched_op;
  logic [WORD_W-1:0] acc_q;

  assign fetched_op = opcode_e'(mem_rdata[WORD_W-1 -: OPC_W]);

  bitser_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (mem_req_ready),
    .fetched_op  (fetched_op),
    .acc_sign    (acc_q[WORD_W-1]),
    .req_valid   (mem_req_valid),
    .req_write   (mem_req_write),
    .addr_from_pc(addr_from_pc),
    .ld_instr    (ld_instr),
    .pc_inc      (pc_inc),
    .pc_jump     (pc_jump),
    .ld_opd      (ld_opd),
    .clr_carry   (clr_carry),
    .shift_en    (shift_en),
    .retire      (instr_retired)
  );

  bitser_addr #(.WORD_W(WORD_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W)) addr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr       (mem_rdata),
    .ld_instr    (ld_instr),
    .pc_inc      (pc_inc),
    .pc_jump     (pc_jump),
    .addr_from_pc(addr_from_pc),
    .pc_q        (pc_o),
    .req_addr    (mem_req_addr),
    .op_q        (op_q)
  );

  bitser_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdata    (mem_rdata),
    .op       (op_q),
    .ld_opd   (ld_opd),
    .clr_carry(clr_carry),
    .shift_en (shift_en),
    .acc_q    (acc_q)
  );

  assign acc_o         = acc_q;
  assign mem_req_wdata = acc_q;
endmodule

// File: rtl/bitser_cpu_chk.sv
module bitser_cpu_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [WORD_W-1:0] mem_req_wdata,
  input logic [WORD_W-1:0] acc_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              instr_retired
);
  assert_reset_arch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc_o == '0) && (acc_o == '0) && !instr_retired);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  assert_retire_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_retired |=> !instr_retired);

  assert_acc_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> $stable(acc_o));

  assert_store_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && mem_req_ready |=> instr_retired && $stable(acc_o));
endmodule

bind bitser_cpu bitser_cpu_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .acc_o        (acc_o),
  .pc_o         (pc_o),
  .instr_retired(instr_retired)
);

// File: tb/bitser_cpu_tb_top.sv
module bitser_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req_valid, mem_req_write, instr_retired;
  logic [29:0] mem_req_addr, pc_o;
  logic [31:0] mem_req_wdata, acc_o;
  logic [31:0] rdata_q = '0;
  logic        ready_q = 1'b1;
  logic        stall_en = 1'b0;
  logic [7:0]  lf = 8'h5A;
  logic [31:0] mem [0:63];
  int errors = 0, checks = 0, hold_viol = 0;

  always #5 clk = ~clk;

  bitser_cpu dut_i (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(ready_q),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(rdata_q),
    .acc_o(acc_o), .pc_o(pc_o), .instr_retired(instr_retired)
  );

  always @(posedge clk) begin
    lf      <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    ready_q <= stall_en ? lf[0] : 1'b1;
    if (rst_n && mem_req_valid && ready_q) begin
      if (mem_req_write) mem[mem_req_addr[5:0]] <= mem_req_wdata;
      else               rdata_q <= mem[mem_req_addr[5:0]];
    end
  end

  logic        pend = 1'b0, p_wr = 1'b0;
  logic [29:0] p_addr = '0;
  logic [31:0] p_wd = '0;
  always @(negedge clk) begin
    if (rst_n && pend && (!mem_req_valid || mem_req_addr != p_addr ||
        mem_req_write != p_wr || mem_req_wdata != p_wd)) hold_viol++;
    pend   = rst_n && mem_req_valid && !ready_q;
    p_addr = mem_req_addr;
    p_wr   = mem_req_write;
    p_wd   = mem_req_wdata;
  end

  function automatic logic [31:0] ins(input logic [1:0] op, input logic [29:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_retire(output int gap);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!instr_retired && n < 3000);
    if (!instr_retired) begin
      errors++;
      $display("FAIL R10 retire timeout: actual=none expected=pulse");
    end
    gap = n;
  endtask

  task automatic t_reset();
    int g;
    clear_mem();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", 32'(pc_o), 32'h0);
    chk("R1", "acc in reset", acc_o, 32'h0);
    chk("R1", "valid in reset", 32'(mem_req_valid), 32'h0);
    chk("R1", "retire in reset", 32'(instr_retired), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first fetch valid", 32'(mem_req_valid), 32'h1);
    chk("R1", "first fetch addr", 32'(mem_req_addr), 32'h0);
    wait_retire(g);
  endtask

  task automatic t_add(input string tag);
    int g;
    clear_mem();
    mem[0] = ins(2'b00, 40); mem[1] = ins(2'b00, 41); mem[2] = ins(2'b00, 42);
    mem[40] = 32'h7FFF_FFFF; mem[41] = 32'h1; mem[42] = 32'h8000_0000;
    do_reset();
    wait_retire(g);
    chk("R3", {tag, " add 7fffffff"}, acc_o, 32'h7FFF_FFFF);
    chk("R8", {tag, " pc after add"}, 32'(pc_o), 32'h1);
    wait_retire(g);
    chk("R3", {tag, " full carry ripple"}, acc_o, 32'h8000_0000);
    if (!stall_en) chk("R10", "add spacing", 32'(g), 32'd36);
    else chk("R9", "stalled add spacing >= 36", 32'(g >= 36), 32'h1);
    wait_retire(g);
    chk("R3", {tag, " wrap mod 2^32"}, acc_o, 32'h0);
    chk("R2", {tag, " pc after three"}, 32'(pc_o), 32'h3);
  endtask

  task automatic t_carry();
    int g;
    clear_mem();
    mem[0] = ins(2'b00, 40); mem[1] = ins(2'b00, 41);
    mem[2] = ins(2'b00, 42); mem[3] = ins(2'b00, 43);
    mem[40] = 32'hFFFF_FFFF; mem[41] = 32'h1; mem[42] = 32'h0; mem[43] = 32'h1234_5678;
    do_reset();
    wait_retire(g); wait_retire(g);
    chk("R3", "ffffffff+1 drops carry", acc_o, 32'h0);
    wait_retire(g);
    chk("R4", "no stale carry into 0+0", acc_o, 32'h0);
    wait_retire(g);
    chk("R4", "clean add after carry out", acc_o, 32'h1234_5678);
  endtask

  task automatic t_nor();
    int g;
    clear_mem();
    mem[0] = ins(2'b01, 40); mem[1] = ins(2'b01, 41); mem[2] = ins(2'b01, 42);
    mem[40] = 32'h0F0F_00FF; mem[41] = 32'h0000_FFFF; mem[42] = 32'hF0F0_FFFF;
    do_reset();
    wait_retire(g);
    chk("R5", "nor with zero acc", acc_o, 32'hF0F0_FF00);
    wait_retire(g);
    chk("R5", "nor mixed", acc_o, 32'h0F0F_0000);
    if (!stall_en) chk("R10", "nor spacing", 32'(g), 32'd36);
    wait_retire(g);
    chk("R5", "nor to all zero", acc_o, 32'h0);
  endtask

  task automatic t_store();
    int g;
    clear_mem();
    mem[0] = ins(2'b00, 40); mem[1] = ins(2'b10, 50); mem[2] = ins(2'b00, 50);
    mem[40] = 32'hDEAD_BEEF;
    do_reset();
    wait_retire(g);
    wait_retire(g);
    chk("R6", "stored word", mem[50], 32'hDEAD_BEEF);
    chk("R6", "acc after store", acc_o, 32'hDEAD_BEEF);
    chk("R8", "pc after store", 32'(pc_o), 32'h2);
    if (!stall_en) chk("R10", "store spacing", 32'(g), 32'd3);
    wait_retire(g);
    chk("R6", "add of stored word", acc_o, 32'hBD5B_7DDE);
  endtask

  task automatic t_jump();
    int g;
    clear_mem();
    mem[0]  = ins(2'b00, 40); mem[1] = ins(2'b11, 10);
    mem[10] = ins(2'b01, 41); mem[11] = ins(2'b11, 20); mem[12] = ins(2'b00, 42);
    mem[40] = 32'h8000_0000; mem[41] = 32'hFFFF_FFFF; mem[42] = 32'h5;
    do_reset();
    wait_retire(g);
    wait_retire(g);
    chk("R7", "taken jump pc", 32'(pc_o), 32'd10);
    if (!stall_en) chk("R10", "jump spacing", 32'(g), 32'd2);
    wait_retire(g);
    chk("R7", "executes at target", acc_o, 32'h0);
    wait_retire(g);
    chk("R7", "not taken pc", 32'(pc_o), 32'd12);
    wait_retire(g);
    chk("R8", "falls through to next", acc_o, 32'h5);
  endtask

  task automatic t_stall();
    stall_en = 1'b1;
    hold_viol = 0;
    t_add("stalled");
    t_store();
    t_jump();
    chk("R9", "held requests stable", 32'(hold_viol), 32'h0);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_add("plain");
    t_carry();
    t_nor();
    t_store();
    t_jump();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule